// File: doc/BRIEF.md
# Multi-Rate PWM Generator

This block drives one pulse-width-modulated output. Software controls it through two byte-wide registers on a simple address, write-data, write-enable and read-data bus. One register holds the enable bit and a two-bit mode field. The mode selects one of four output rates: 250 Hz, 500 Hz, 1 kHz or 2 kHz. The other register holds a 7-bit duty value. Both registers can be read back.

All four rates share one base tick. A divider derives this tick from the system clock, and its default rate is 128 times the slowest output rate. A period counter advances once per tick and wraps after 128, 64, 32 or 16 ticks, depending on the mode. The output is high while the counter is below the duty value. This means each mode has its own duty resolution. The slowest mode has a full-scale count of 128, which the 7-bit duty field cannot hold, so that mode cannot produce a constant-high output. For a constant-high output, software selects the 500 Hz mode and writes the largest duty value.

Mode and duty changes are staged: the counter keeps using the old pair until the end of the running period. This keeps truncated pulses off the output.

Top module: `pwm_multirate`

## Requirements
- R1: After reset, both registers read 0x00 and the output is low.
- R2: Offset 0 is the control register: bit 7 is the enable and bits [1:0] are the mode. Offset 1 is the duty register: bits [6:0] hold the duty. Read data returns the stored value as soon as the write has taken effect. Unused bits read as zero and are discarded on write.
- R3: The period counter advances by one for every base tick. The base tick comes once every CLK_HZ/TICK_HZ system clocks, so a duty of 1 gives a high pulse of exactly that many clocks.
- R4: The period lasts 128, 64, 32 or 16 ticks for mode 0, 1, 2 or 3 respectively.
- R5: While the block is enabled, the output is high for exactly `duty` ticks of each period, at the start of the period.
- R6: A duty value at or above the mode's full-scale count (128 >> mode) gives a constant-high output. For example, mode 1 with duty 0x7f is constant high.
- R7: In mode 0, the largest duty value (0x7f) gives 127 high ticks out of 128, never a constant high.
- R8: While the enable bit is clear, the output is low and the period counter is held at zero.
- R9: A new duty or mode value is applied only at the next period boundary. A pulse that is already running completes with its old width.
- R10: A duty of zero while the block is enabled gives a constant-low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench uses several corner cases to tell the design's failure modes apart:
- **Mode 0 at duty 0x7f:** A compare that wraps the 7-bit field, or one that treats 0x7f as full scale, would show as a constant high here instead of one low tick per period.
- **Mode 1 at duty 0x7f and mode 3 at exactly full scale:** These catch a compare that stops at the wrap value and so drops the output for the last tick.
- **Mid-pulse duty shrink:** The bench shrinks the duty while a pulse is high. An unstaged design would cut that pulse short, and a design that never reloads would keep the old width into the next period.
- **Disable with duty at maximum:** This shows whether the enable truly forces the output low, rather than only stopping the counter.

// File: rtl/pwm_mr_pkg.sv
package pwm_mr_pkg;

  localparam int CNT_W    = 7;
  localparam int OFS_CTRL = 0;
  localparam int OFS_DUTY = 1;
  localparam int EN_BIT   = 7;

  typedef enum logic [1:0] {
    MODE_SLOW  = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_QUART = 2'd2,
    MODE_FAST  = 2'd3
  } pwm_mode_e;

  // Full-scale duty count of a mode: 128 >> mode.
  function automatic logic [7:0] full_of(pwm_mode_e m);
    return 8'd128 >> m;
  endfunction

  // Last counter value of a period.
  function automatic logic [CNT_W-1:0] wrap_of(pwm_mode_e m);
    logic [7:0] fs;
    fs = full_of(m);
    return CNT_W'(fs - 8'd1);
  endfunction

  // Output level for a counter position and a duty value.
  function automatic logic level_of(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] duty);
    return cnt < duty;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_mr_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  output logic              en,
  output pwm_mode_e         mode,
  output logic [CNT_W-1:0]  duty
);

  logic             en_q;
  pwm_mode_e        mode_q;
  logic [CNT_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_SLOW;
      duty_q <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(OFS_CTRL)) begin
        en_q   <= wdata[EN_BIT];
        mode_q <= pwm_mode_e'(wdata[1:0]);
      end else if (addr == ADDR_W'(OFS_DUTY)) begin
        duty_q <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata[EN_BIT] = en_q;
      rdata[1:0]    = mode_q;
    end else if (addr == ADDR_W'(OFS_DUTY)) begin
      rdata[CNT_W-1:0] = duty_q;
    end
  end

  assign en   = en_q;
  assign mode = mode_q;
  assign duty = duty_q;

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DIV = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
  import pwm_mr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  pwm_mode_e        mode_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             pwm_out,
  output logic             run,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] duty_act,
  output pwm_mode_e        mode_act
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_q;
  pwm_mode_e        mode_q;
  logic             at_wrap;
  logic             load;

  assign at_wrap  = (cnt_q == wrap_of(mode_q));
  assign boundary = run_q & tick & at_wrap;
  assign load     = !run_q | boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      duty_q <= '0;
      mode_q <= MODE_SLOW;
    end else begin
      run_q <= en;
      if (load) begin
        duty_q <= duty_in;
        mode_q <= mode_in;
      end
      if (!run_q)     cnt_q <= '0;
      else if (tick)  cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign pwm_out  = run_q & level_of(cnt_q, duty_q);
  assign run      = run_q;
  assign cnt      = cnt_q;
  assign duty_act = duty_q;
  assign mode_act = mode_q;

endmodule

// File: rtl/pwm_multirate.sv
module pwm_multirate
  import pwm_mr_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 32_000,
  parameter int ADDR_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              pwm_out
);

  localparam int TICK_DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  logic             ctrl_en_w;
  pwm_mode_e        ctrl_mode_w;
  logic [CNT_W-1:0] duty_reg_w;
  logic             tick_w;
  logic             run_w;
  logic             boundary_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] duty_act_w;
  pwm_mode_e        mode_act_w;

  pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .rdata (bus_rdata),
    .en    (ctrl_en_w),
    .mode  (ctrl_mode_w),
    .duty  (duty_reg_w)
  );

  pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w)
  );

  pwm_period_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .en       (ctrl_en_w),
    .mode_in  (ctrl_mode_w),
    .duty_in  (duty_reg_w),
    .pwm_out  (pwm_out),
    .run      (run_w),
    .boundary (boundary_w),
    .cnt      (cnt_w),
    .duty_act (duty_act_w),
    .mode_act (mode_act_w)
  );

endmodule

// File: rtl/pwm_multirate_chk.sv
module pwm_multirate_chk
  import pwm_mr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             run_w,
  input logic             tick_w,
  input logic             boundary_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] duty_act_w,
  input pwm_mode_e        mode_act_w
);

  AST_STEP_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && !tick_w |=> $stable(cnt_w)); // R3

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= wrap_of(mode_act_w)); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_w |=> cnt_w == '0); // R4

  AST_FULL_SCALE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && ({1'b0, duty_act_w} >= full_of(mode_act_w)) |-> pwm_out); // R6

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> !pwm_out); // R8

  AST_OFF_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> cnt_w == '0); // R8

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && !boundary_w |=> $stable(duty_act_w) && $stable(mode_act_w)); // R9

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> cnt_w == '0); // R9

endmodule

bind pwm_multirate pwm_multirate_chk u_chk (.*);

// File: tb/sim_pwm_multirate.sv
module sim_pwm_multirate;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  typedef struct {
    int req;
    int settle;
    int window;
    int exp_hi;
  } sb_item_t;

  sb_item_t sb_q[$];
  bit       sb_busy = 1'b0;

  always #10 clk = ~clk;

  pwm_multirate #(.CLK_HZ(128), .TICK_HZ(32), .ADDR_W(1)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input int req, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Driver: configures the block and queues the high-count it should produce.
  task automatic expect_duty(input int req, input int mode, input int duty, input bit en);
    sb_item_t it;
    int full;
    int eff;
    full = 128 >> mode;
    eff  = en ? ((duty < full) ? duty : full) : 0;
    wr(1'b1, 8'(duty));
    wr(1'b0, {en, 5'd0, 2'(mode)});
    it.req    = req;
    it.settle = 1100;
    it.window = 2 * full * DIV;
    it.exp_hi = 2 * eff * DIV;
    sb_q.push_back(it);
    wait (sb_q.size() == 0 && !sb_busy);
  endtask

  // Monitor: counts high samples over whole periods and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0 && !sb_busy) begin
        sb_item_t it;
        int hi;
        it = sb_q.pop_front();
        sb_busy = 1'b1;
        repeat (it.settle) @(negedge clk);
        hi = 0;
        repeat (it.window) begin
          @(negedge clk);
          if (pwm_out) hi++;
        end
        chk(it.req, hi, it.exp_hi, "high samples per window");
        sb_busy = 1'b0;
      end
    end
  end

  task automatic measure_pulse(output int hi, output int per);
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
    hi = 0;
    do begin hi++; @(negedge clk); end while (pwm_out);
    per = hi;
    do begin per++; @(negedge clk); end while (!pwm_out);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int hi;
    int per;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d); chk(1, d, 8'h00, "control after reset");
    rd(1'b1, d); chk(1, d, 8'h00, "duty after reset");
    repeat (20) @(negedge clk);
    chk(1, pwm_out, 0, "output after reset");

    // R2 readback with unused bits dropped
    wr(1'b0, 8'hFF); rd(1'b0, d); chk(2, d, 8'h83, "control readback");
    wr(1'b1, 8'hFF); rd(1'b1, d); chk(2, d, 8'h7F, "duty readback");

    // R8 disabled with duty at maximum: always low
    expect_duty(8, 1, 8'h7f, 1'b0);
    rd(1'b0, d); chk(8, d, 8'h01, "control readback while disabled");

    // R10 duty zero: always low
    expect_duty(10, 2, 0, 1'b1);

    // R5 proportional duty in two modes
    expect_duty(5, 0, 8'h40, 1'b1);
    expect_duty(5, 2, 10, 1'b1);

    // R7 slowest mode cannot reach constant high
    expect_duty(7, 0, 8'h7f, 1'b1);

    // R6 full scale and above give constant high
    expect_duty(6, 1, 8'h7f, 1'b1);
    expect_duty(6, 3, 8'h10, 1'b1);

    // R3 and R4: duty 1 pulse is one tick; period per mode
    for (int m = 0; m < 4; m++) begin
      wr(1'b1, 8'd1);
      wr(1'b0, {1'b1, 5'd0, 2'(m)});
      repeat (1100) @(negedge clk);
      measure_pulse(hi, per);
      chk(3, hi, DIV, "one-tick pulse width");
      chk(4, per, (128 >> m) * DIV, "period length");
    end

    // R9 duty shrink mid-pulse applies only from the next period
    wr(1'b1, 8'd48);
    wr(1'b0, 8'h81);
    repeat (1100) @(negedge clk);
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
    hi = 0;
    do begin
      hi++;
      if (hi == 32) begin
        bus_addr  = 1'b1;
        bus_wdata = 8'd4;
        bus_we    = 1'b1;
      end else begin
        bus_we = 1'b0;
      end
      @(negedge clk);
    end while (pwm_out);
    bus_we = 1'b0;
    chk(9, hi, 48 * DIV, "running pulse keeps old width");
    measure_pulse(hi, per);
    chk(9, hi, 4 * DIV, "next pulse uses new width");
    chk(9, per, 64 * DIV, "period unchanged");

    finish_run();
  end

endmodule